// File: doc/BRIEF.md
# Four-Stage Instruction Cycle Sequencer

This block is the control sequencer of a word-serial computer. It steps the machine through a repeating cycle of four stages. In the first stage the control-counter word is fetched. In the second stage a memory word holding two instructions is fetched. The third stage executes the left instruction and the fourth executes the right one.

Each stage opens with a time-out lasting one minor cycle, so that decoded control levels can settle. During that time nothing else may happen. Instruction execution, memory and arithmetic live elsewhere. They report completion of a stage through a single ending pulse. On each accepted ending pulse the sequencer gives the load strobes for the control register, the static register (with a selector for which half of the word is taken) and the control-counter increment.

An error request is remembered. It stops the sequencer at the next time-out period, and the sequencer stays stopped until reset.

Top module: `cyc_seq`

## Requirements
- R1: A synchronous active-high `rst` puts the sequencer in stage code 00 with `timeout` high, `halted` low and all strobes low.
- R2: Each accepted ending pulse advances `stage` in the order 00 (control fetch), 01 (pair fetch), 10 (left execute), 11 (right execute), then back to 00. `stage` changes on no other event.
- R3: The clock edge that advances the stage also raises `timeout`.
- R4: While `timeout` is high, all strobes stay low and `end_pulse` is ignored. A cycle with `minor_tick` high during time-out (and no pending error) clears `timeout` at the next edge. Without a tick, `timeout` stays high.
- R5: An accepted ending pulse in stage 00 asserts `cr_load` and `sr_load` with `sr_left`=0 (digits 7 to 12) in that same cycle, and `cc_inc` stays low.
- R6: An accepted ending pulse in stage 01 asserts `cr_load`, `sr_load` with `sr_left`=1 (digits 1 to 6) and `cc_inc` in that same cycle.
- R7: An accepted ending pulse in stage 10 asserts only `sr_load` with `sr_left`=0. In stage 11 it asserts no strobe.
- R8: In stage 01, an ending pulse is accepted only if `mem_ready` is high in that cycle or was high in an earlier cycle of the same stage after its time-out. A `mem_ready` seen during the time-out does not count. An ending pulse that is not accepted leaves the stage unchanged.
- R9: `err_req` is remembered. `halted` rises one edge after a cycle in which `timeout` is high and the error is already pending, never earlier. A tick in the same cycle as the request still clears the time-out, so the stop waits for the following time-out.
- R10: Once halted, `halted` and `timeout` stay high, `stage` is frozen and all strobes stay low whatever the inputs, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| minor_tick | input | 1 | Minor-cycle boundary pulse |
| end_pulse | input | 1 | Stage-ending pulse from the execution logic |
| mem_ready | input | 1 | Memory word available |
| err_req | input | 1 | Error stop request |
| stage | output | 2 | Current stage code |
| timeout | output | 1 | Time-out period active |
| halted | output | 1 | Sequencer stopped by an error |
| cr_load | output | 1 | Control register load strobe |
| sr_load | output | 1 | Static register load strobe |
| sr_left | output | 1 | 1: static register takes digits 1 to 6; 0: digits 7 to 12 |
| cc_inc | output | 1 | Control counter increment strobe |

## Verification
Two functions can fall in the same cycle here, and the bench drives both cases at once.

The first is the time-out clear and the error capture. The bench raises `minor_tick` and `err_req` in one time-out cycle. It expects `timeout` to fall and `halted` to stay low. The stop then follows one edge after the next ending pulse re-enters a time-out, with that pulse's strobes still issued.

The second is in the pair-fetch stage, where `mem_ready` and `end_pulse` can arrive together. The bench checks that the pulse is accepted in that case. It also checks that a ready seen only during the time-out leaves a lone ending pulse without effect.

// File: rtl/cyc_seq_pkg.sv
package cyc_seq_pkg;

  typedef enum logic [1:0] {
    ST_ALPHA = 2'b00,
    ST_BETA  = 2'b01,
    ST_GAMMA = 2'b10,
    ST_DELTA = 2'b11
  } stage_e;

  typedef struct packed {
    logic cr_load;
    logic sr_load;
    logic sr_left;
    logic cc_inc;
  } strobe_t;

  // Stages wrap around in a fixed order.
  function automatic stage_e stage_after(input stage_e s);
    return stage_e'(s + 2'd1);
  endfunction

  // Strobes issued when a stage is ended.
  function automatic strobe_t stage_strobes(input stage_e s);
    strobe_t r;
    r = '0;
    case (s)
      ST_ALPHA: begin r.cr_load = 1'b1; r.sr_load = 1'b1; end
      ST_BETA:  begin r.cr_load = 1'b1; r.sr_load = 1'b1; r.sr_left = 1'b1; r.cc_inc = 1'b1; end
      ST_GAMMA: begin r.sr_load = 1'b1; end
      default:  r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cyc_stage_reg.sv
module cyc_stage_reg
  import cyc_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   adv_i,
  input  logic   clr_i,
  output stage_e stage_o,
  output logic   tmo_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_o <= ST_ALPHA;
      tmo_o   <= 1'b1;
    end else begin
      if (adv_i) stage_o <= stage_after(stage_o);
      if (adv_i)      tmo_o <= 1'b1;
      else if (clr_i) tmo_o <= 1'b0;
    end
  end

endmodule

// File: rtl/cyc_mem_gate.sv
module cyc_mem_gate (
  input  logic clk,
  input  logic rst,
  input  logic watch_i,
  input  logic ready_i,
  input  logic clr_i,
  output logic seen_o,
  output logic ok_o
);

  always_ff @(posedge clk) begin
    if (rst)                    seen_o <= 1'b0;
    else if (clr_i)             seen_o <= 1'b0;
    else if (watch_i && ready_i) seen_o <= 1'b1;
  end

  assign ok_o = seen_o | (watch_i & ready_i);

endmodule

// File: rtl/cyc_halt.sv
module cyc_halt (
  input  logic clk,
  input  logic rst,
  input  logic err_i,
  input  logic tmo_i,
  output logic pend_o,
  output logic halted_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_o   <= 1'b0;
      halted_o <= 1'b0;
    end else begin
      if (err_i && !halted_o) pend_o <= 1'b1;
      if (tmo_i && pend_o)    halted_o <= 1'b1;
    end
  end

endmodule

// File: rtl/cyc_seq.sv
module cyc_seq
  import cyc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       minor_tick,
  input  logic       end_pulse,
  input  logic       mem_ready,
  input  logic       err_req,
  output logic [1:0] stage,
  output logic       timeout,
  output logic       halted,
  output logic       cr_load,
  output logic       sr_load,
  output logic       sr_left,
  output logic       cc_inc
);

  stage_e  stage_q;
  logic    active;
  logic    err_pend;
  logic    tmo_clear;
  logic    fetch_watch;
  logic    fetch_seen;
  logic    fetch_ok;
  logic    end_acc;
  strobe_t strb;

  assign active      = !halted && !timeout;
  assign tmo_clear   = timeout && minor_tick && !halted && !err_pend;
  assign fetch_watch = active && (stage_q == ST_BETA);
  assign end_acc     = active && end_pulse && ((stage_q != ST_BETA) || fetch_ok);
  assign strb        = end_acc ? stage_strobes(stage_q) : '0;

  cyc_stage_reg i_stage (
    .clk(clk), .rst(rst), .adv_i(end_acc), .clr_i(tmo_clear),
    .stage_o(stage_q), .tmo_o(timeout)
  );

  cyc_mem_gate i_gate (
    .clk(clk), .rst(rst), .watch_i(fetch_watch), .ready_i(mem_ready),
    .clr_i(end_acc), .seen_o(fetch_seen), .ok_o(fetch_ok)
  );

  cyc_halt i_halt (
    .clk(clk), .rst(rst), .err_i(err_req), .tmo_i(timeout),
    .pend_o(err_pend), .halted_o(halted)
  );

  assign stage   = stage_q;
  assign cr_load = strb.cr_load;
  assign sr_load = strb.sr_load;
  assign sr_left = strb.sr_left;
  assign cc_inc  = strb.cc_inc;

endmodule

// File: rtl/cyc_seq_chk.sv
module cyc_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] stage,
  input logic       timeout,
  input logic       halted,
  input logic       end_pulse,
  input logic       mem_ready,
  input logic       end_acc,
  input logic       fetch_seen,
  input logic       cr_load,
  input logic       sr_load,
  input logic       sr_left,
  input logic       cc_inc
);

  // R2
  adv_order_chk: assert property (@(posedge clk) disable iff (rst)
    end_acc |=> (stage == 2'($past(stage) + 2'd1)));

  // R2
  stage_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !end_acc |=> $stable(stage));

  // R3
  tmo_after_end_chk: assert property (@(posedge clk) disable iff (rst)
    end_acc |=> timeout);

  // R4
  quiet_timeout_chk: assert property (@(posedge clk) disable iff (rst)
    timeout |-> !(cr_load || sr_load || cc_inc));

  // R6
  inc_only_beta_chk: assert property (@(posedge clk) disable iff (rst)
    cc_inc |-> (stage == 2'b01 && cr_load && sr_left));

  // R8
  beta_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (stage == 2'b01 && !timeout && !halted && end_pulse && !fetch_seen && !mem_ready)
      |=> (stage == 2'b01));

  // R9
  halt_at_tmo_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(halted) |-> $past(timeout));

  // R10
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && timeout && $stable(stage)));

endmodule

bind cyc_seq cyc_seq_chk i_chk (
  .clk(clk), .rst(rst), .stage(stage), .timeout(timeout), .halted(halted),
  .end_pulse(end_pulse), .mem_ready(mem_ready), .end_acc(end_acc),
  .fetch_seen(fetch_seen), .cr_load(cr_load), .sr_load(sr_load),
  .sr_left(sr_left), .cc_inc(cc_inc)
);

// File: tb/test_cyc_seq.sv
module test_cyc_seq;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       minor_tick = 1'b0;
  logic       end_pulse = 1'b0;
  logic       mem_ready = 1'b0;
  logic       err_req = 1'b0;
  logic [1:0] stage;
  logic       timeout, halted, cr_load, sr_load, sr_left, cc_inc;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  cyc_seq i_cyc_seq (
    .clk(clk), .rst(rst), .minor_tick(minor_tick), .end_pulse(end_pulse),
    .mem_ready(mem_ready), .err_req(err_req), .stage(stage), .timeout(timeout),
    .halted(halted), .cr_load(cr_load), .sr_load(sr_load), .sr_left(sr_left),
    .cc_inc(cc_inc)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic t, input logic e, input logic r, input logic x);
    @(negedge clk);
    minor_tick = t; end_pulse = e; mem_ready = r; err_req = x;
    #2;
  endtask

  // Expected strobe pattern as a 4-bit number {cr, sr, left, inc}.
  function automatic int exp_strb(input int s, input bit acc);
    int v;
    v = 0;
    if (acc) begin
      if (s <= 1) v += 8;
      if (s != 3) v += 4;
      if (s == 1) v += 3;
    end
    return v;
  endfunction

  function automatic int got_strb();
    return {28'd0, cr_load, sr_load, sr_left, cc_inc};
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    apply(0, 0, 0, 0);
    apply(0, 0, 0, 0);
    // R1 reset state
    chk(stage == 2'd0, "R1", "stage", stage, 0);
    chk(timeout == 1'b1, "R1", "timeout", timeout, 1);
    chk(halted == 1'b0, "R1", "halted", halted, 0);
    chk(got_strb() == 0, "R1", "strobes", got_strb(), 0);
    rst = 1'b0;
  endtask

  // Leave time-out and end the current stage with memory ready.
  task automatic run_stage();
    apply(1, 0, 0, 0);
    apply(0, 1, 1, 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int exp_stage;
    do_reset();
    exp_stage = 0;

    for (int cyc = 0; cyc < 3; cyc++) begin
      for (int st = 0; st < 4; st++) begin
        int wt;
        wt = (cyc + st) % 3;
        // R4 ending pulse during time-out is ignored (ready shown too in beta)
        apply(0, 1, (st == 1), 0);
        chk(got_strb() == 0, "R4", "strobes in timeout", got_strb(), 0);
        for (int k = 0; k < wt; k++) begin
          apply(0, 0, 0, 0);
          chk(timeout == 1'b1 && stage == 2'(exp_stage), "R4", "timeout held", timeout, 1);
        end
        apply(1, 0, 0, 0);
        apply(0, 0, 0, 0);
        chk(timeout == 1'b0, "R4", "timeout cleared", timeout, 0);
        if (st == 1) begin
          // R8 no ready in active part yet: pulse ignored
          apply(0, 1, 0, 0);
          chk(got_strb() == 0, "R8", "strobes without ready", got_strb(), 0);
          apply(0, 0, 0, 0);
          chk(stage == 2'd1, "R8", "stage without ready", stage, 1);
          if (cyc != 0) begin
            apply(0, 0, 1, 0);
            if (cyc == 2) apply(0, 0, 0, 0);
          end
          apply(0, 1, (cyc == 0), 0);
        end else begin
          apply(0, 1, 0, 0);
        end
        // R5 R6 R7 strobes of the ending stage
        chk(got_strb() == exp_strb(st, 1'b1),
            st == 0 ? "R5" : (st == 1 ? "R6" : "R7"), "strobes",
            got_strb(), exp_strb(st, 1'b1));
        apply(0, 0, 0, 0);
        exp_stage = (exp_stage + 1) % 4;
        chk(stage == 2'(exp_stage), "R2", "stage order", stage, exp_stage);
        chk(timeout == 1'b1, "R3", "timeout after end", timeout, 1);
        chk(halted == 1'b0, "R10", "not halted", halted, 0);
      end
    end

    // R9 tick and error in the same time-out cycle
    apply(1, 0, 0, 1);
    apply(0, 0, 0, 0);
    chk(timeout == 1'b0, "R9", "timeout cleared with err", timeout, 0);
    chk(halted == 1'b0, "R9", "no early halt", halted, 0);
    apply(0, 1, 0, 0);
    chk(got_strb() == exp_strb(0, 1'b1), "R9", "strobes before stop", got_strb(), exp_strb(0, 1'b1));
    apply(0, 0, 0, 0);
    chk(stage == 2'd1 && timeout == 1'b1, "R9", "stage before stop", stage, 1);
    chk(halted == 1'b0, "R9", "halt one edge later", halted, 0);
    apply(0, 0, 0, 0);
    chk(halted == 1'b1, "R9", "halted", halted, 1);
    // R10 frozen
    for (int k = 0; k < 4; k++) begin
      apply(1, 1, 1, 1);
      chk(got_strb() == 0, "R10", "strobes halted", got_strb(), 0);
      chk(stage == 2'd1 && timeout == 1'b1 && halted == 1'b1, "R10", "frozen stage", stage, 1);
    end

    // R9 error during time-out, no tick
    do_reset();
    apply(0, 0, 0, 1);
    apply(0, 0, 0, 0);
    chk(halted == 1'b0, "R9", "pending not halted", halted, 0);
    apply(0, 0, 0, 0);
    chk(halted == 1'b1, "R9", "halt in timeout", halted, 1);
    apply(1, 0, 0, 0);
    apply(0, 0, 0, 0);
    chk(timeout == 1'b1 && stage == 2'd0, "R10", "tick ignored", timeout, 1);

    // R9 error during an active stage waits for the next time-out
    do_reset();
    run_stage();
    run_stage();
    apply(1, 0, 0, 0);
    apply(0, 0, 0, 1);
    apply(0, 0, 0, 0);
    apply(0, 0, 0, 0);
    chk(halted == 1'b0 && timeout == 1'b0, "R9", "not immediate", halted, 0);
    apply(0, 1, 0, 0);
    chk(got_strb() == exp_strb(2, 1'b1), "R7", "left exec strobes", got_strb(), exp_strb(2, 1'b1));
    apply(0, 0, 0, 0);
    chk(stage == 2'd3 && halted == 1'b0, "R9", "enter timeout", stage, 3);
    apply(0, 0, 0, 0);
    chk(halted == 1'b1, "R9", "halt at timeout", halted, 1);

    // R1 reset leaves halt
    do_reset();
    apply(0, 0, 0, 0);
    chk(halted == 1'b0 && stage == 2'd0, "R1", "after halt reset", halted, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule